// File: doc/BRIEF.md
# Relative Branch Execution Unit

This unit executes the relative-branch group and the branch-to-subroutine instruction of an 8-bit CPU core. When `start` is pulsed, it latches the opcode, the signed displacement byte, the six condition flags, the level of the external interrupt request pin, the program counter and the stack pointer. It then checks the selected condition and produces the next program counter. For a subroutine call it also produces the two byte-wide stack writes and the updated stack pointer.

The unit works from the captured values only. A new `start` has no effect until the current instruction has finished. A conditional or unconditional branch finishes in its third cycle, where the cycle with `start` counts as the first. A subroutine call finishes in its fifth cycle. An opcode outside the supported set finishes one cycle after `start` and sets an error flag. In that case the unit requests no program counter or stack pointer update and writes nothing to the stack. The unit has no condition-code output, so it cannot change any flag.

Top module: `rbranch_unit`

## Requirements
- R1: While reset is asserted and after it is released, `busy`, `done`, `taken`, `err`, `pc_wr`, `sp_wr` and `st_we` are all 0.
- R2: Opcode 0x20 is always taken and opcode 0x21 is never taken. For a branch, `done` is high for one cycle, exactly 2 cycles after the cycle in which `start` was sampled, so the instruction takes 3 cycles.
- R3: With `ccr[0]`=C and `ccr[1]`=Z, these opcodes are taken when the condition holds: 0x22 when (C|Z)=0, 0x23 when (C|Z)=1, 0x24 when C=0, 0x25 when C=1, 0x26 when Z=0.
- R4: With `ccr[2]`=N, `ccr[3]`=I and `ccr[4]`=H, these opcodes are taken when the condition holds: 0x29 when H=1, 0x2A when N=0, 0x2B when N=1, 0x2C when I=0, 0x2D when I=1.
- R5: Opcode 0x2E is taken when `irq_pin` is 0 and opcode 0x2F when it is 1. The level used is the one sampled together with `start`.
- R6: With `ccr[5]`=V, `ccr[2]`=N and `ccr[1]`=Z, opcode 0x91 is taken when (N^V)=1 and opcode 0x93 when Z|(N^V)=1.
- R7: The next address is `pc_in`+2. When a branch is taken, `pc_out` equals that next address plus the sign-extended displacement, modulo 2^16. When it is not taken, `pc_out` equals the next address.
- R8: For opcode 0xAD, `st_we` is high in exactly two cycles. In cycle start+2 it writes address `sp_in` with the low byte of `pc_in`+2. In cycle start+3 it writes address `sp_in`-1 with the high byte.
- R9: For opcode 0xAD, `done`, `pc_wr`, `sp_wr` and `taken` are high in cycle start+4, with `pc_out` = `pc_in`+2+sext(disp) and `sp_out` = `sp_in`-2.
- R10: A branch finishes with `pc_wr`=1 and `sp_wr`=0 and makes no stack write.
- R11: Any other opcode gives `done` and `err` in cycle start+1. In that cycle `pc_wr`=0, `sp_wr`=0 and `taken`=0, and there is no stack write.
- R12: A `start` pulse while `busy` is high produces no extra completion and does not change the result of the instruction in progress.
- R13: `done` lasts exactly one cycle. `busy` is high from the cycle after `start` through the `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an instruction; ignored while busy |
| opcode | input | 8 | Decoded opcode byte |
| disp | input | 8 | Signed displacement byte |
| ccr | input | 6 | Flags {V,H,I,N,Z,C}, C in bit 0 |
| irq_pin | input | 1 | External interrupt request pin level |
| pc_in | input | 16 | Address of the opcode byte |
| sp_in | input | 16 | Current stack pointer |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Final cycle of the instruction |
| taken | output | 1 | Branch taken, valid with `done` |
| err | output | 1 | Unrecognised opcode, valid with `done` |
| pc_wr | output | 1 | Load `pc_out` into the program counter |
| pc_out | output | 16 | New program counter |
| sp_wr | output | 1 | Load `sp_out` into the stack pointer |
| sp_out | output | 16 | New stack pointer |
| st_we | output | 1 | Stack byte write strobe |
| st_addr | output | 16 | Stack write address |
| st_data | output | 8 | Stack write data |

## Verification
Each result is due a fixed number of cycles after the cycle that samples `start`. A branch completes 2 cycles later. A fault completes 1 cycle later. A call writes its two stack bytes 2 and 3 cycles later and completes 4 cycles later. For every stimulus, the driver records the cycle of the `start` cycle and queues each expected beat and result with its due cycle. The monitor samples on the falling edge, compares the cycle number along with the data, and reports any write or completion for which nothing was queued.

// File: rtl/rbranch_pkg.sv
package rbranch_pkg;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_EVAL,
    SEQ_BR_END,
    SEQ_PUSH_LO,
    SEQ_PUSH_HI,
    SEQ_CALL_END,
    SEQ_FAULT
  } seq_state_e;

  typedef enum logic [1:0] {
    CLS_BRANCH,
    CLS_CALL,
    CLS_BAD
  } op_class_e;

  typedef enum logic [3:0] {
    TST_ALWAYS,
    TST_NEVER,
    TST_ABOVE,
    TST_NOT_ABOVE,
    TST_CARRY_CLR,
    TST_CARRY_SET,
    TST_NONZERO,
    TST_HALF_SET,
    TST_POSITIVE,
    TST_NEGATIVE,
    TST_MASK_CLR,
    TST_MASK_SET,
    TST_PIN_LOW,
    TST_PIN_HIGH,
    TST_SLESS,
    TST_SLESS_EQ
  } test_sel_e;

  // bit 5 down to bit 0
  typedef struct packed {
    logic v;
    logic h;
    logic i;
    logic n;
    logic z;
    logic c;
  } flags_t;

endpackage

// File: rtl/rbranch_decode.sv
module rbranch_decode
  import rbranch_pkg::*;
#(
  parameter int unsigned OP_W = 8
) (
  input  logic [OP_W-1:0] opcode,
  output op_class_e       cls,
  output test_sel_e       tst
);

  always_comb begin
    cls = CLS_BRANCH;
    tst = TST_NEVER;
    case (opcode)
      OP_W'(8'h20): tst = TST_ALWAYS;
      OP_W'(8'h21): tst = TST_NEVER;
      OP_W'(8'h22): tst = TST_ABOVE;
      OP_W'(8'h23): tst = TST_NOT_ABOVE;
      OP_W'(8'h24): tst = TST_CARRY_CLR;
      OP_W'(8'h25): tst = TST_CARRY_SET;
      OP_W'(8'h26): tst = TST_NONZERO;
      OP_W'(8'h29): tst = TST_HALF_SET;
      OP_W'(8'h2A): tst = TST_POSITIVE;
      OP_W'(8'h2B): tst = TST_NEGATIVE;
      OP_W'(8'h2C): tst = TST_MASK_CLR;
      OP_W'(8'h2D): tst = TST_MASK_SET;
      OP_W'(8'h2E): tst = TST_PIN_LOW;
      OP_W'(8'h2F): tst = TST_PIN_HIGH;
      OP_W'(8'h91): tst = TST_SLESS;
      OP_W'(8'h93): tst = TST_SLESS_EQ;
      OP_W'(8'hAD): begin
        cls = CLS_CALL;
        tst = TST_ALWAYS;
      end
      default: begin
        cls = CLS_BAD;
        tst = TST_NEVER;
      end
    endcase
  end

endmodule

// File: rtl/rbranch_cond.sv
module rbranch_cond
  import rbranch_pkg::*;
(
  input  test_sel_e tst,
  input  flags_t    fl,
  input  logic      pin,
  output logic      take
);

  logic ord_low;
  logic sgn_lt;

  assign ord_low = fl.c | fl.z;
  assign sgn_lt  = fl.n ^ fl.v;

  always_comb begin
    unique case (tst)
      TST_ALWAYS:    take = 1'b1;
      TST_NEVER:     take = 1'b0;
      TST_ABOVE:     take = ~ord_low;
      TST_NOT_ABOVE: take = ord_low;
      TST_CARRY_CLR: take = ~fl.c;
      TST_CARRY_SET: take = fl.c;
      TST_NONZERO:   take = ~fl.z;
      TST_HALF_SET:  take = fl.h;
      TST_POSITIVE:  take = ~fl.n;
      TST_NEGATIVE:  take = fl.n;
      TST_MASK_CLR:  take = ~fl.i;
      TST_MASK_SET:  take = fl.i;
      TST_PIN_LOW:   take = ~pin;
      TST_PIN_HIGH:  take = pin;
      TST_SLESS:     take = sgn_lt;
      TST_SLESS_EQ:  take = fl.z | sgn_lt;
      default:       take = 1'b0;
    endcase
  end

endmodule

// File: rtl/rbranch_seq.sv
module rbranch_seq
  import rbranch_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  op_class_e  cls,
  output logic       busy,
  output logic       ev_capture,
  output logic       ev_eval,
  output logic       ev_push_lo,
  output logic       ev_push_hi,
  output logic       ev_br_end,
  output logic       ev_call_end,
  output logic       ev_fault
);

  seq_state_e state_q, state_d;
  logic       call_q;

  assign ev_capture  = start && (state_q == SEQ_IDLE);
  assign ev_eval     = (state_q == SEQ_EVAL);
  assign ev_push_lo  = (state_q == SEQ_PUSH_LO);
  assign ev_push_hi  = (state_q == SEQ_PUSH_HI);
  assign ev_br_end   = (state_q == SEQ_BR_END);
  assign ev_call_end = (state_q == SEQ_CALL_END);
  assign ev_fault    = (state_q == SEQ_FAULT);
  assign busy        = (state_q != SEQ_IDLE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE: begin
        if (ev_capture) state_d = (cls == CLS_BAD) ? SEQ_FAULT : SEQ_EVAL;
      end
      SEQ_EVAL:     state_d = call_q ? SEQ_PUSH_LO : SEQ_BR_END;
      SEQ_PUSH_LO:  state_d = SEQ_PUSH_HI;
      SEQ_PUSH_HI:  state_d = SEQ_CALL_END;
      SEQ_BR_END,
      SEQ_CALL_END,
      SEQ_FAULT:    state_d = SEQ_IDLE;
      default:      state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      call_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (ev_capture) call_q <= (cls == CLS_CALL);
    end
  end

endmodule

// File: rtl/rbranch_unit.sv
module rbranch_unit
  import rbranch_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned DISP_W   = 8,
  parameter int unsigned BYTE_W   = 8,
  parameter int unsigned OP_W     = 8,
  parameter int unsigned INSN_LEN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [OP_W-1:0]   opcode,
  input  logic [DISP_W-1:0] disp,
  input  logic [5:0]        ccr,
  input  logic              irq_pin,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [ADDR_W-1:0] sp_in,
  output logic              busy,
  output logic              done,
  output logic              taken,
  output logic              err,
  output logic              pc_wr,
  output logic [ADDR_W-1:0] pc_out,
  output logic              sp_wr,
  output logic [ADDR_W-1:0] sp_out,
  output logic              st_we,
  output logic [ADDR_W-1:0] st_addr,
  output logic [BYTE_W-1:0] st_data
);

  localparam int unsigned EXT_W = ADDR_W - DISP_W;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_LEN);
  localparam logic [ADDR_W-1:0] ONE  = ADDR_W'(1);

  // sign-extend the displacement to a full address
  function automatic logic [ADDR_W-1:0] widen_disp(input logic [DISP_W-1:0] d);
    return {{EXT_W{d[DISP_W-1]}}, d};
  endfunction

  // destination relative to the following instruction
  function automatic logic [ADDR_W-1:0] branch_dest(input logic [ADDR_W-1:0] base,
                                                     input logic [DISP_W-1:0] d);
    return base + widen_disp(d);
  endfunction

  op_class_e  cls_w;
  test_sel_e  tst_w;
  logic       take_w;
  logic       ev_capture, ev_eval, ev_push_lo, ev_push_hi;
  logic       ev_br_end, ev_call_end, ev_fault;

  test_sel_e         tst_q;
  flags_t            fl_q;
  logic              pin_q;
  logic [DISP_W-1:0] disp_q;
  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] sp_q;
  logic [ADDR_W-1:0] link_q;
  logic              taken_q;

  rbranch_decode #(.OP_W(OP_W)) u_decode (
    .opcode (opcode),
    .cls    (cls_w),
    .tst    (tst_w)
  );

  rbranch_cond u_cond (
    .tst  (tst_q),
    .fl   (fl_q),
    .pin  (pin_q),
    .take (take_w)
  );

  rbranch_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .cls         (cls_w),
    .busy        (busy),
    .ev_capture  (ev_capture),
    .ev_eval     (ev_eval),
    .ev_push_lo  (ev_push_lo),
    .ev_push_hi  (ev_push_hi),
    .ev_br_end   (ev_br_end),
    .ev_call_end (ev_call_end),
    .ev_fault    (ev_fault)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tst_q   <= TST_NEVER;
      fl_q    <= '0;
      pin_q   <= 1'b0;
      disp_q  <= '0;
      pc_q    <= '0;
      sp_q    <= '0;
      link_q  <= '0;
      taken_q <= 1'b0;
    end else begin
      if (ev_capture) begin
        tst_q  <= tst_w;
        fl_q   <= flags_t'(ccr);
        pin_q  <= irq_pin;
        disp_q <= disp;
        pc_q   <= pc_in;
        sp_q   <= sp_in;
      end
      if (ev_eval) begin
        link_q  <= pc_q + STEP;
        taken_q <= take_w;
      end
      if (ev_push_lo || ev_push_hi) sp_q <= sp_q - ONE;
    end
  end

  assign st_we   = ev_push_lo | ev_push_hi;
  assign st_addr = sp_q;
  assign st_data = ev_push_hi ? link_q[ADDR_W-1 -: BYTE_W] : link_q[BYTE_W-1:0];

  assign done   = ev_br_end | ev_call_end | ev_fault;
  assign err    = ev_fault;
  assign taken  = (ev_br_end | ev_call_end) & taken_q;
  assign pc_wr  = ev_br_end | ev_call_end;
  assign sp_wr  = ev_call_end;
  assign sp_out = sp_q;
  assign pc_out = ev_fault ? pc_q : (taken_q ? branch_dest(link_q, disp_q) : link_q);

endmodule

// File: rtl/rbranch_unit_chk.sv
module rbranch_unit_chk #(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              taken,
  input logic              err,
  input logic              pc_wr,
  input logic              sp_wr,
  input logic [ADDR_W-1:0] sp_out,
  input logic              st_we,
  input logic [ADDR_W-1:0] st_addr,
  input logic              ev_push_lo,
  input logic              ev_push_hi
);

  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  // R13
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R13
  done_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  // R11
  fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (done && !pc_wr && !sp_wr && !taken && !st_we));

  // R8
  push_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_push_lo |=> (ev_push_hi && st_we && (st_addr == $past(st_addr) - ONE)));

  // R9
  call_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_push_hi |=> (done && pc_wr && sp_wr && taken && (sp_out == $past(st_addr) - ONE)));

  // R10
  beat_inside_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_we |-> (busy && !done));

  // R12
  launch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R12
  hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy && !done) |=> busy);

endmodule

bind rbranch_unit rbranch_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .busy       (busy),
  .done       (done),
  .taken      (taken),
  .err        (err),
  .pc_wr      (pc_wr),
  .sp_wr      (sp_wr),
  .sp_out     (sp_out),
  .st_we      (st_we),
  .st_addr    (st_addr),
  .ev_push_lo (ev_push_lo),
  .ev_push_hi (ev_push_hi)
);

// File: tb/rbranch_unit_test.sv
module rbranch_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic [7:0]  disp = 8'h00;
  logic [5:0]  ccr = 6'h00;
  logic        irq_pin = 1'b0;
  logic [15:0] pc_in = 16'h0000;
  logic [15:0] sp_in = 16'h0000;
  logic        busy, done, taken, err, pc_wr, sp_wr, st_we;
  logic [15:0] pc_out, sp_out, st_addr;
  logic [7:0]  st_data;

  always #4 clk = ~clk;

  rbranch_unit uut (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .disp(disp),
    .ccr(ccr), .irq_pin(irq_pin), .pc_in(pc_in), .sp_in(sp_in),
    .busy(busy), .done(done), .taken(taken), .err(err),
    .pc_wr(pc_wr), .pc_out(pc_out), .sp_wr(sp_wr), .sp_out(sp_out),
    .st_we(st_we), .st_addr(st_addr), .st_data(st_data)
  );

  typedef struct packed {
    logic [31:0] due;
    logic        tk;
    logic        er;
    logic        pw;
    logic        sw;
    logic [15:0] pc;
    logic [15:0] sp;
  } res_t;

  typedef struct packed {
    logic [31:0] due;
    logic [15:0] addr;
    logic [7:0]  data;
  } beat_t;

  res_t  res_q[$];
  string res_tag[$];
  beat_t beat_q[$];

  int  cyc = 0;
  int  vectors = 0;
  int  miscompares = 0;
  int  dones_seen = 0;
  int  dones_expected = 0;
  bit  finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // returns {known, is_call, take}
  function automatic logic [2:0] ref_eval(input logic [7:0] op, input logic [5:0] f,
                                          input logic pin);
    logic c, z, n, i, h, v;
    c = f[0]; z = f[1]; n = f[2]; i = f[3]; h = f[4]; v = f[5];
    case (op)
      8'h20: return 3'b101;
      8'h21: return 3'b100;
      8'h22: return {2'b10, !(c || z)};
      8'h23: return {2'b10, (c || z)};
      8'h24: return {2'b10, !c};
      8'h25: return {2'b10, c};
      8'h26: return {2'b10, !z};
      8'h29: return {2'b10, h};
      8'h2A: return {2'b10, !n};
      8'h2B: return {2'b10, n};
      8'h2C: return {2'b10, !i};
      8'h2D: return {2'b10, i};
      8'h2E: return {2'b10, pin == 1'b0};
      8'h2F: return {2'b10, pin == 1'b1};
      8'h91: return {2'b10, n != v};
      8'h93: return {2'b10, z || (n != v)};
      8'hAD: return 3'b111;
      default: return 3'b000;
    endcase
  endfunction

  function automatic string ref_tag(input logic [7:0] op);
    case (op)
      8'h20, 8'h21: return "R2";
      8'h22, 8'h23, 8'h24, 8'h25, 8'h26: return "R3";
      8'h2E, 8'h2F: return "R5";
      8'h91, 8'h93: return "R6";
      default: return "R4";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, got, exp);
    end
  endtask

  // monitor: compare design output against the queued expectations
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (st_we) begin
        if (beat_q.size() == 0) begin
          check(1'b0, "R10", "stray stack write", {32'(cyc), st_addr}, 64'h0);
        end else begin
          beat_t b;
          b = beat_q.pop_front();
          check(st_addr == b.addr && st_data == b.data && cyc == int'(b.due), "R8",
                "stack beat {cycle,addr,data}", {16'(cyc), st_addr, st_data},
                {16'(b.due), b.addr, b.data});
        end
      end
      if (done) begin
        dones_seen++;
        if (res_q.size() == 0) begin
          check(1'b0, "R12", "unexpected completion", 64'(cyc), 64'h0);
        end else begin
          res_t  r;
          string t;
          logic [63:0] got_v, exp_v;
          r = res_q.pop_front();
          t = res_tag.pop_front();
          got_v = {12'(cyc), taken, err, pc_wr, sp_wr, pc_out, sp_out};
          exp_v = {12'(r.due), r.tk, r.er, r.pw, r.sw, r.pc, r.sp};
          check(got_v == exp_v, t, "{cycle,taken,err,pc_wr,sp_wr,pc,sp}", got_v, exp_v);
        end
      end
    end
  end

  // driver: launch one instruction and queue what it must produce
  task automatic run_op(input logic [7:0] op, input logic [7:0] d, input logic [5:0] f,
                        input logic pin, input logic [15:0] pc, input logic [15:0] sp,
                        input string tag, input bit poke);
    logic [2:0]  m;
    logic [15:0] nxt, tgt;
    int          s;
    res_t        r;
    beat_t       b;
    @(negedge clk);
    opcode = op; disp = d; ccr = f; irq_pin = pin; pc_in = pc; sp_in = sp;
    start = 1'b1;
    s = cyc;
    m = ref_eval(op, f, pin);
    nxt = pc + 16'd2;
    tgt = nxt + {{8{d[7]}}, d};
    if (!m[2]) begin
      r = '{due: 32'(s + 1), tk: 1'b0, er: 1'b1, pw: 1'b0, sw: 1'b0, pc: pc, sp: sp};
    end else if (m[1]) begin
      b = '{due: 32'(s + 2), addr: sp, data: nxt[7:0]};
      beat_q.push_back(b);
      b = '{due: 32'(s + 3), addr: sp - 16'd1, data: nxt[15:8]};
      beat_q.push_back(b);
      r = '{due: 32'(s + 4), tk: 1'b1, er: 1'b0, pw: 1'b1, sw: 1'b1, pc: tgt, sp: sp - 16'd2};
    end else begin
      r = '{due: 32'(s + 2), tk: m[0], er: 1'b0, pw: 1'b1, sw: 1'b0,
            pc: m[0] ? tgt : nxt, sp: 16'h0000};
      r.sp = sp_out_dc(sp);
    end
    res_q.push_back(r);
    res_tag.push_back(tag);
    dones_expected++;
    @(negedge clk);
    start = 1'b0;
    irq_pin = ~pin;             // R5: later pin changes must not matter
    ccr = ~f;
    if (poke) begin
      start = 1'b1;             // R12: start while busy
      opcode = 8'h20; disp = 8'h7F; pc_in = 16'hAAAA; sp_in = 16'h5555;
      @(negedge clk);
      start = 1'b0;
    end
    while (res_q.size() != 0) @(negedge clk);
  endtask

  // a branch leaves the captured stack pointer on sp_out
  function automatic logic [15:0] sp_out_dc(input logic [15:0] sp);
    return sp;
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] ops [16];
    ops = '{8'h20, 8'h21, 8'h22, 8'h23, 8'h24, 8'h25, 8'h26, 8'h29,
            8'h2A, 8'h2B, 8'h2C, 8'h2D, 8'h2E, 8'h2F, 8'h91, 8'h93};

    // R1: reset state
    repeat (3) @(negedge clk);
    check({busy, done, taken, err, pc_wr, sp_wr, st_we} == 7'b0, "R1", "outputs in reset",
          {busy, done, taken, err, pc_wr, sp_wr, st_we}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check({busy, done, taken, err, pc_wr, sp_wr, st_we} == 7'b0, "R1", "outputs after reset",
          {busy, done, taken, err, pc_wr, sp_wr, st_we}, 0);

    // R2 directed
    run_op(8'h20, 8'h10, 6'h3F, 1'b0, 16'h1000, 16'h0100, "R2", 1'b0);
    run_op(8'h21, 8'h10, 6'h00, 1'b1, 16'h1000, 16'h0100, "R2", 1'b0);

    // R3 R4 R5 R6 R10: every condition opcode against every flag pattern and pin level
    foreach (ops[k]) begin
      for (int f = 0; f < 64; f++) begin
        for (int p = 0; p < 2; p++) begin
          run_op(ops[k], 8'(f * 5 + 3), 6'(f), 1'(p), 16'(16'h4000 + f * 9),
                 16'h0200, ref_tag(ops[k]), 1'b0);
        end
      end
    end

    // R7: backward and forward wrap of the target
    run_op(8'h20, 8'h80, 6'h00, 1'b0, 16'h0010, 16'h0300, "R7", 1'b0);
    run_op(8'h20, 8'h05, 6'h00, 1'b0, 16'hFFFE, 16'h0300, "R7", 1'b0);
    run_op(8'h24, 8'hFE, 6'h00, 1'b0, 16'h8000, 16'h0300, "R7", 1'b0);

    // R8 R9: subroutine calls, including stack pointer wrap
    run_op(8'hAD, 8'hF0, 6'h15, 1'b0, 16'h2345, 16'h00FF, "R9", 1'b0);
    run_op(8'hAD, 8'h22, 6'h2A, 1'b1, 16'hFFFF, 16'h0000, "R9", 1'b0);
    run_op(8'hAD, 8'h7F, 6'h00, 1'b0, 16'h0000, 16'h0001, "R9", 1'b0);

    // R11: unrecognised opcodes
    run_op(8'h27, 8'h10, 6'h02, 1'b0, 16'h1234, 16'h0400, "R11", 1'b0);
    run_op(8'h00, 8'h10, 6'h00, 1'b0, 16'h1234, 16'h0400, "R11", 1'b0);
    run_op(8'h92, 8'h10, 6'h00, 1'b0, 16'h1234, 16'h0400, "R11", 1'b0);
    run_op(8'hFF, 8'h10, 6'h00, 1'b0, 16'h1234, 16'h0400, "R11", 1'b0);

    // R12: start while busy, on a call and on a branch
    run_op(8'hAD, 8'h04, 6'h00, 1'b0, 16'h3000, 16'h01F0, "R12", 1'b1);
    run_op(8'h26, 8'h04, 6'h00, 1'b0, 16'h3100, 16'h01F0, "R12", 1'b1);

    repeat (8) @(negedge clk);
    // R12 R13: no completion beyond the ones requested, unit back to idle
    check(dones_seen == dones_expected, "R12", "completion count", 64'(dones_seen),
          64'(dones_expected));
    check(!busy && beat_q.size() == 0, "R13", "idle after last instruction",
          {busy, 32'(beat_q.size())}, 0);

    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule